// File: doc/BRIEF.md
# Link Integrity Monitor

The block decides whether a 100 Mb/s copper link may be reported as up. It watches a receive-signal-valid indication from the equalizer. The indication must stay high without a break for a programmable number of clock cycles before the link counts as qualified. The count is set from the clock frequency so that it covers a line settling time of about 330 µs, for example 8250 cycles at 25 MHz.

Once the link is qualified, the machine does one of two things:
- If auto-negotiation is enabled, it parks in a ready state and waits for a grant from the negotiation logic.
- If auto-negotiation is disabled, it goes straight to link-up.

Losing the valid indication in any state drops the link on the next clock edge and restarts the qualification count.

In link-up the block raises an enable for the transmit and receive datapaths. The reported link status feeds both the LED and the status register bit. It normally follows the machine. When 10BASE-T operation is selected, the reported status follows the 10 Mb/s receiver's own link indication instead. Both outputs are registered.

Top module: `link_integrity_mon`

## Requirements
- R1: While reset (`rst_n` low) is held and at the first edge after it with `sig_valid` low, `link_up` and `trx_en` are 0 and the machine is in the down state.
- R2: From the down state, the machine leaves down only at the clock edge that samples `sig_valid` high for the QUAL_CYCLES-th consecutive time. A single low sample resets the run, and the next run starts again from zero.
- R3: With `aneg_on`=1, qualification moves the machine to a ready state in which `link_up` and `trx_en` stay 0. At the first edge that samples `aneg_grant`=1 in ready, the machine moves to up.
- R4: With `aneg_on`=0, the qualifying edge moves the machine directly to up. A ready machine that samples `aneg_on`=0 also moves to up at that edge.
- R5: Any edge that samples `sig_valid`=0 puts the machine in the down state, so `link_up` (outside 10BASE-T mode) and `trx_en` are 0 after that edge.
- R6: `trx_en` is 1 exactly in the cycles following an edge at which the machine is in up. It changes only on clock edges.
- R7: When an edge samples `mode_10m`=1, `link_up` after that edge equals the `link_10m` value sampled at that edge. When it samples `mode_10m`=0, `link_up` equals the up state. `trx_en` and the machine are not affected by `mode_10m`.
- R8: `aneg_grant` sampled while the machine is still in the down state has no effect: after qualification with `aneg_on`=1, the machine stays in ready until a grant arrives while it is in ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_valid | input | 1 | Receive signal valid from the equalizer |
| aneg_on | input | 1 | Auto-negotiation enabled |
| aneg_grant | input | 1 | Link enable grant from auto-negotiation |
| mode_10m | input | 1 | Select 10BASE-T link status for reporting |
| link_10m | input | 1 | Link indication from the 10 Mb/s receiver |
| link_up | output | 1 | Reported link status (registered) |
| trx_en | output | 1 | Transmit/receive datapath enable (registered) |

## Verification
The assertions assume that all inputs are synchronous to `clk` and stable around its rising edge. They also assume that reset is applied before the first meaningful sample, since the grant-wait and drop properties compare against the previous edge's inputs.

The bench changes inputs only at the falling edge. It holds them through each rising edge, and it draws random values for `sig_valid`, the grant, the negotiation enable and the 10 Mb/s inputs from a fixed seed. `sig_valid` is biased high so that the qualification count is often reached. Directed sequences cover the exact qualifying edge, an interrupted run, an early grant and clearing negotiation while in ready.

// File: rtl/link_integrity_mon_pkg.sv
package link_integrity_mon_pkg;

    typedef enum logic [1:0] {
        LNK_DOWN  = 2'd0,
        LNK_READY = 2'd1,
        LNK_UP    = 2'd2
    } lnk_state_e;

endpackage

// File: rtl/link_qual_timer.sv
module link_qual_timer #(
    parameter int QUAL_CYCLES = 8250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_valid,
    output logic qual_done
);
    localparam int CW = $clog2(QUAL_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] run;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!sig_valid) begin
            tmr_d.run = '0;
        end else if (tmr_q.run != LAST) begin
            tmr_d.run = tmr_q.run + 1'b1;
        end
        qual_done = sig_valid && (tmr_q.run == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R2: the run count saturates at its terminal value
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.run <= LAST);

endmodule

// File: rtl/link_state_core.sv
module link_state_core
    import link_integrity_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig_valid,
    input  logic       qual_done,
    input  logic       aneg_on,
    input  logic       aneg_grant,
    output lnk_state_e state,
    output logic       up_next,
    output logic       up_q
);
    typedef struct packed {
        lnk_state_e st;
        logic       up;
    } core_t;

    core_t core_d, core_q;

    always_comb begin
        core_d = core_q;
        if (!sig_valid) begin
            core_d.st = LNK_DOWN;
        end else begin
            unique case (core_q.st)
                LNK_DOWN: begin
                    if (qual_done) core_d.st = aneg_on ? LNK_READY : LNK_UP;
                end
                LNK_READY: begin
                    if (!aneg_on || aneg_grant) core_d.st = LNK_UP;
                end
                LNK_UP:  core_d.st = LNK_UP;
                default: core_d.st = LNK_DOWN;
            endcase
        end
        core_d.up = (core_d.st == LNK_UP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '{st: LNK_DOWN, up: 1'b0};
        else        core_q <= core_d;
    end

    assign state   = core_q.st;
    assign up_q    = core_q.up;
    assign up_next = core_d.up;

    // R5: loss of valid always lands in the down state
    p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sig_valid |=> (core_q.st == LNK_DOWN));

    // R3: ready waits while negotiation is on and no grant is seen
    p_wait_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == LNK_READY && sig_valid && aneg_on && !aneg_grant)
        |=> (core_q.st == LNK_READY));

    // R2: down is left only on a qualifying edge
    p_hold_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == LNK_DOWN && !qual_done) |=> (core_q.st == LNK_DOWN));

endmodule

// File: rtl/link_status_out.sv
module link_status_out (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_10m,
    input  logic link_10m,
    input  logic up_next,
    output logic link_up
);
    typedef struct packed {
        logic link;
    } sts_t;

    sts_t sts_d, sts_q;

    always_comb begin
        sts_d      = sts_q;
        sts_d.link = mode_10m ? link_10m : up_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= sts_d;
    end

    assign link_up = sts_q.link;

    // R7: in 10BASE-T mode the reported status tracks the 10 Mb/s indication
    p_ten_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_10m |=> (link_up == $past(link_10m)));

endmodule

// File: rtl/link_integrity_mon.sv
module link_integrity_mon
    import link_integrity_mon_pkg::*;
#(
    parameter int QUAL_CYCLES = 8250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_valid,
    input  logic aneg_on,
    input  logic aneg_grant,
    input  logic mode_10m,
    input  logic link_10m,
    output logic link_up,
    output logic trx_en
);
    logic       qual_done;
    logic       up_next;
    logic       up_q;
    lnk_state_e state;

    link_qual_timer #(.QUAL_CYCLES(QUAL_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_valid (sig_valid),
        .qual_done (qual_done)
    );

    link_state_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .sig_valid  (sig_valid),
        .qual_done  (qual_done),
        .aneg_on    (aneg_on),
        .aneg_grant (aneg_grant),
        .state      (state),
        .up_next    (up_next),
        .up_q       (up_q)
    );

    link_status_out u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_10m (mode_10m),
        .link_10m (link_10m),
        .up_next  (up_next),
        .link_up  (link_up)
    );

    assign trx_en = up_q;

    // R6: the datapath enable is never high after an edge that saw valid low
    p_trx_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trx_en |-> $past(sig_valid));

    // R6: the enable matches the machine's up state
    p_trx_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trx_en == (state == LNK_UP));

    // R1: outputs are clear while reset is held
    always_comb begin
        if (!rst_n) begin
            a_reset_r1: assert (!(state == LNK_UP));
        end
    end

endmodule

// File: tb/link_integrity_mon_bench.sv
module link_integrity_mon_bench;
    localparam int N = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sig_valid = 1'b0, aneg_on = 1'b0, aneg_grant = 1'b0;
    logic mode_10m = 1'b0, link_10m = 1'b0;
    logic link_up, trx_en;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    int m_cnt = 0;   // consecutive valid samples
    int m_st  = 0;   // 0 down, 1 ready, 2 up
    bit m_link = 0;

    always #2.5 clk = ~clk;

    link_integrity_mon #(.QUAL_CYCLES(N)) u_link_integrity_mon (
        .clk(clk), .rst_n(rst_n), .sig_valid(sig_valid), .aneg_on(aneg_on),
        .aneg_grant(aneg_grant), .mode_10m(mode_10m), .link_10m(link_10m),
        .link_up(link_up), .trx_en(trx_en)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish (actual cycles %0d, expected < 150000)", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic int next_st(int st, int cnt, bit dv, bit an, bit gr);
        if (!dv) return 0;
        if (st == 0) return (cnt == N - 1) ? (an ? 1 : 2) : 0;
        if (st == 1) return (!an || gr) ? 2 : 1;
        return 2;
    endfunction

    function automatic int next_cnt(int cnt, bit dv);
        if (!dv) return 0;
        return (cnt == N - 1) ? cnt : cnt + 1;
    endfunction

    task automatic chk(string req, logic got, logic exp, string what);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b (cycle %0d)", req, what, got, exp, cyc);
        end
    endtask

    // drive at negedge, model the edge, check at the following negedge
    task automatic step(bit dv, bit an, bit gr, bit ten, bit l10, string req);
        sig_valid = dv; aneg_on = an; aneg_grant = gr; mode_10m = ten; link_10m = l10;
        @(posedge clk);
        m_st   = next_st(m_st, m_cnt, dv, an, gr);
        m_cnt  = next_cnt(m_cnt, dv);
        m_link = ten ? l10 : (m_st == 2);
        @(negedge clk);
        chk(req, link_up, m_link, "link_up");
        chk(req, trx_en, (m_st == 2), "trx_en");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", link_up, 1'b0, "link_up in reset");
        chk("R1", trx_en, 1'b0, "trx_en in reset");
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, "R1");

        // R2/R4: exact qualifying edge, negotiation off
        for (int i = 0; i < N - 1; i++) step(1, 0, 0, 0, 0, "R2");
        chk("R2", trx_en, 1'b0, "one sample short of qualification");
        step(1, 0, 0, 0, 0, "R4");
        chk("R4", link_up, 1'b1, "direct up with negotiation off");

        // R5: drop from up
        step(0, 0, 0, 0, 0, "R5");
        chk("R5", trx_en, 1'b0, "dropped after valid loss");

        // R2: interrupted run restarts
        for (int i = 0; i < N - 3; i++) step(1, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, "R2");
        for (int i = 0; i < N - 1; i++) step(1, 0, 0, 0, 0, "R2");
        chk("R2", trx_en, 1'b0, "run restarted after glitch");
        step(1, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, "R5");

        // R8/R3: early grant ignored, ready waits, grant moves to up
        for (int i = 0; i < N; i++) step(1, 1, 1, 0, 0, "R8");
        for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 0, "R8");
        chk("R8", link_up, 1'b0, "early grant had no effect");
        step(1, 1, 1, 0, 0, "R3");
        chk("R3", trx_en, 1'b1, "grant in ready");

        // R5 from ready, then R4 ready with negotiation cleared
        step(0, 1, 0, 0, 0, "R5");
        for (int i = 0; i < N + 2; i++) step(1, 1, 0, 0, 0, "R3");
        chk("R3", trx_en, 1'b0, "parked in ready");
        step(0, 1, 0, 0, 0, "R5");
        for (int i = 0; i < N; i++) step(1, 1, 0, 0, 0, "R3");
        step(1, 0, 0, 0, 0, "R4");
        chk("R4", trx_en, 1'b1, "ready leaves when negotiation cleared");

        // R7: 10BASE-T status overrides, machine unaffected
        step(1, 0, 0, 1, 0, "R7");
        chk("R7", link_up, 1'b0, "10M status low");
        chk("R7", trx_en, 1'b1, "machine still up");
        step(0, 0, 0, 1, 1, "R7");
        chk("R7", link_up, 1'b1, "10M status high with valid low");

        // random mix
        void'($urandom(32'd1234));
        for (int i = 0; i < 6000; i++) begin
            bit dv  = ($urandom % 40) != 0;
            bit an  = ($urandom % 8) != 0;
            bit gr  = ($urandom % 30) == 0;
            bit ten = ($urandom % 10) == 0;
            bit l10 = $urandom % 2;
            step(dv, an, gr, ten, l10, ten ? "R7" : "R6");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule